// File: doc/BRIEF.md
# Circular receive frame store

This block sits behind an address filter and lands accepted frames from a byte-wide receive stream in a circular byte memory. The host programs the ring bounds and advances a tail pointer as it consumes frames. Every stored frame is preceded by a six-byte header that holds a forward link to the following frame and a 32-bit status word. Each frame is padded so that the next one begins on an even address.

Nothing becomes visible to the host until a frame is complete. On the last byte of an accepted frame the header is filled in, the hardware write pointer jumps to the forward link, the pending-frame count goes up and the received flag is set, all in one clock edge. A frame that does not fit in the space between the write pointer and the host tail is dropped. The write pointer stays where it was, and a sticky error flag is raised. The host reads stored bytes back through a combinational peek port.

Top module: `ring_rx_writer`

## Requirements
- R1: Reset clears the write pointer, pending count, both flags and the interrupt. While `rx_enable` is low, the write pointer loads `ring_start` on every clock. A frame whose first byte arrives while `rx_enable` is low changes nothing.
- R2: The six header bytes sit at the frame's start address, which is the old write pointer, in this order: forward link low byte, forward link high byte (the address zero-extended to 16 bits), status bits 7:0, 15:8, 23:16, 31:24. Status bits 15:0 are the data byte count. Status bits 31:16 are `in_stat` as sampled with the last byte.
- R3: Data bytes are stored in arrival order, starting at the address that follows the header.
- R4: Every address step, whether for header, data or padding, goes from `ring_end` back to `ring_start`. The write pointer always stays inside the ring.
- R5: The forward link is the address that follows the last data byte. If that address is odd, one more step is taken, which skips one padding byte. `ring_start` must be even and `ring_end` odd, so frames always start on even addresses.
- R6: The write pointer, pending count and received flag change only on the clock edge that takes the last byte of an accepted frame. That edge sets the write pointer to the forward link, adds one to the count and sets the flag.
- R7: A frame whose last byte has `in_pass` low leaves no trace: pointer, count and both flags are unchanged.
- R8: Free space is the number of bytes from the write pointer up to the host tail, minus one. A passing frame whose header, data and padding bytes together exceed the free space is dropped. A drop sets the error flag and leaves the pointer and count unchanged.
- R9: `pend_dec` lowers a non-zero count by one. The received flag clears when the count reaches zero. `err_clr` clears the error flag, but a drop in the same cycle wins.
- R10: `irq` is high when `glob_ie` is high and either (received flag and `pkt_ie`) or (error flag and `err_ie`) is true.
- R11: The pending count saturates at its maximum value, which is 15 with the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception enable |
| ring_start | input | AW | First ring address (even) |
| ring_end | input | AW | Last ring address (odd) |
| host_tail | input | AW | Host read position that bounds the free space |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Stream byte |
| in_pass | input | 1 | Filter verdict, sampled with the last byte |
| in_stat | input | 16 | Receive statistics, sampled with the last byte |
| pend_dec | input | 1 | Host has consumed one frame |
| err_clr | input | 1 | Clear the error flag |
| pkt_ie | input | 1 | Received interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| peek_addr | input | AW | Memory read address |
| peek_data | output | 8 | Memory read data |
| hw_wr_ptr | output | AW | Committed write pointer |
| pend_count | output | CW | Pending frame count |
| pkt_flag | output | 1 | Frame received flag |
| err_flag | output | 1 | Drop error flag |
| irq | output | 1 | Interrupt request |

## Verification
Frames of even length, odd length and a single byte are sent back to back while the host tail follows the write pointer, so the ring wraps partway through headers and data. These cases separate the padding rule from plain advancement and show that the wrap applies to every kind of byte. A failing frame between passing ones shows that a rejected frame leaves nothing behind. Two frames of the same odd length are offered with free space one byte apart. That pair shows the padding byte is counted in the fit test. A run of more frames than the counter holds exposes saturation.

// File: rtl/ring_rx_pkg.sv
package ring_rx_pkg;
  localparam int HDR_BYTES = 6;
  localparam int LEN_W     = 16;

  typedef struct packed {
    logic [15:0]      rx_stat;
    logic [LEN_W-1:0] byte_cnt;
  } rsv_t;
endpackage

// File: rtl/ring_walk.sv
// Produces N successive ring addresses after base, wrapping hi -> lo.
module ring_walk #(
  parameter int AW = 8,
  parameter int N  = 2
) (
  input  logic [AW-1:0]        lo,
  input  logic [AW-1:0]        hi,
  input  logic [AW-1:0]        base,
  output logic [N-1:0][AW-1:0] seq
);
  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_step
      logic [AW-1:0] prev;
      if (k == 0) begin : g_first
        assign prev = base;
      end else begin : g_rest
        assign prev = seq[k-1];
      end
      assign seq[k] = (prev == hi) ? lo : prev + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ring_space.sv
// Free bytes between committed write pointer and host tail, one kept unused.
module ring_space #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] wp,
  input  logic [AW-1:0] tail,
  output logic [AW:0]   free
);
  logic [AW:0] size;
  always_comb begin
    size = {1'b0, hi} - {1'b0, lo} + 1'b1;
    if (tail > wp) free = {1'b0, tail} - {1'b0, wp} - 1'b1;
    else           free = size - ({1'b0, wp} - {1'b0, tail}) - 1'b1;
  end
endmodule

// File: rtl/ring_mem.sv
// Byte store with one data write port and a header write group.
module ring_mem #(
  parameter int AW = 8,
  parameter int HN = 6
) (
  input  logic                  clk,
  input  logic                  d_we,
  input  logic [AW-1:0]         d_addr,
  input  logic [7:0]            d_data,
  input  logic                  h_we,
  input  logic [HN-1:0][AW-1:0] h_addr,
  input  logic [HN-1:0][7:0]    h_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (d_we) mem_q[d_addr] <= d_data;
    if (h_we) begin
      for (int k = 0; k < HN; k++) mem_q[h_addr[k]] <= h_data[k];
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ring_flags.sv
// Pending count, received and error flags, interrupt combine.
module ring_flags #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          drop,
  input  logic          dec,
  input  logic          err_clr,
  input  logic          pkt_ie,
  input  logic          err_ie,
  input  logic          glob_ie,
  output logic [CW-1:0] cnt,
  output logic          pkt_flag,
  output logic          err_flag,
  output logic          irq
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pkt_q, pkt_d, err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    if (commit && !(dec && cnt_q != '0)) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (!commit && dec && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    pkt_d = commit ? 1'b1 : ((cnt_d == '0) ? 1'b0 : pkt_q);
    err_d = drop ? 1'b1 : (err_clr ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pkt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pkt_q <= pkt_d;
      err_q <= err_d;
    end
  end

  assign cnt      = cnt_q;
  assign pkt_flag = pkt_q;
  assign err_flag = err_q;
  assign irq      = glob_ie & ((pkt_q & pkt_ie) | (err_q & err_ie));
endmodule

// File: rtl/ring_rx_writer.sv
module ring_rx_writer
  import ring_rx_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_end,
  input  logic [AW-1:0] host_tail,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  input  logic          in_pass,
  input  logic [15:0]   in_stat,
  input  logic          pend_dec,
  input  logic          err_clr,
  input  logic          pkt_ie,
  input  logic          err_ie,
  input  logic          glob_ie,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data,
  output logic [AW-1:0] hw_wr_ptr,
  output logic [CW-1:0] pend_count,
  output logic          pkt_flag,
  output logic          err_flag,
  output logic          irq
);
  localparam logic [LEN_W-1:0] FILL_HDR1 = LEN_W'(HDR_BYTES + 1);
  localparam logic [LEN_W-1:0] FILL_MAX  = '1;

  // registered frame state
  logic [AW-1:0]    wp_q, wp_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic [LEN_W-1:0] fill_q, fill_d;
  logic             act_q, act_d;
  logic             ovf_q, ovf_d;

  // combinational frame decode
  logic [HDR_BYTES-1:0][AW-1:0] hseq;
  logic [1:0][AW-1:0]           nseq;
  logic [AW:0]                  free;
  logic [AW-1:0]                baddr, nextp;
  logic [LEN_W-1:0]             fill_now;
  logic [LEN_W:0]               need;
  logic                         take, ovf_now, pad, fits;
  logic                         commit, drop, d_we;
  rsv_t                         rsv;
  logic [15:0]                  link16;
  logic [HDR_BYTES-1:0][AW-1:0] h_addr;
  logic [HDR_BYTES-1:0][7:0]    h_data;

  ring_walk #(.AW(AW), .N(HDR_BYTES)) u_hdr_walk (
    .lo(ring_start), .hi(ring_end), .base(wp_q), .seq(hseq)
  );

  ring_walk #(.AW(AW), .N(2)) u_next_walk (
    .lo(ring_start), .hi(ring_end), .base(baddr), .seq(nseq)
  );

  ring_space #(.AW(AW)) u_space (
    .lo(ring_start), .hi(ring_end), .wp(wp_q), .tail(host_tail), .free(free)
  );

  always_comb begin
    take     = in_valid && rx_enable && (in_sof || act_q);
    baddr    = in_sof ? hseq[HDR_BYTES-1] : cur_q;
    fill_now = in_sof ? FILL_HDR1 : ((fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1);
    ovf_now  = (in_sof ? 1'b0 : ovf_q) || ({1'b0, fill_now} > (LEN_W+1)'(free));
    pad      = nseq[0][0];
    nextp    = pad ? nseq[1] : nseq[0];
    need     = {1'b0, fill_now} + (LEN_W+1)'(pad);
    fits     = !ovf_now && (need <= (LEN_W+1)'(free));
    d_we     = take && !ovf_now;
    commit   = take && in_eof && in_pass && fits;
    drop     = take && in_eof && in_pass && !fits;

    rsv.byte_cnt = fill_now - LEN_W'(HDR_BYTES);
    rsv.rx_stat  = in_stat;
    link16       = 16'(nextp);
    h_addr[0]    = wp_q;
    for (int k = 1; k < HDR_BYTES; k++) h_addr[k] = hseq[k-1];
    h_data[0] = link16[7:0];
    h_data[1] = link16[15:8];
    h_data[2] = rsv[7:0];
    h_data[3] = rsv[15:8];
    h_data[4] = rsv[23:16];
    h_data[5] = rsv[31:24];
  end

  // next-state
  always_comb begin
    wp_d   = wp_q;
    cur_d  = cur_q;
    fill_d = fill_q;
    act_d  = act_q;
    ovf_d  = ovf_q;
    if (!rx_enable) begin
      wp_d  = ring_start;
      act_d = 1'b0;
    end else begin
      if (commit) wp_d = nextp;
      if (take) begin
        cur_d  = nseq[0];
        fill_d = fill_now;
        ovf_d  = ovf_now;
        act_d  = !in_eof;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      cur_q  <= '0;
      fill_q <= '0;
      act_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      cur_q  <= cur_d;
      fill_q <= fill_d;
      act_q  <= act_d;
      ovf_q  <= ovf_d;
    end
  end

  ring_mem #(.AW(AW), .HN(HDR_BYTES)) u_mem (
    .clk(clk), .d_we(d_we), .d_addr(baddr), .d_data(in_data),
    .h_we(commit), .h_addr(h_addr), .h_data(h_data),
    .rd_addr(peek_addr), .rd_data(peek_data)
  );

  ring_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .commit(commit), .drop(drop), .dec(pend_dec),
    .err_clr(err_clr), .pkt_ie(pkt_ie), .err_ie(err_ie), .glob_ie(glob_ie),
    .cnt(pend_count), .pkt_flag(pkt_flag), .err_flag(err_flag), .irq(irq)
  );

  assign hw_wr_ptr = wp_q;
endmodule

// File: rtl/ring_rx_writer_chk.sv
module ring_rx_writer_chk #(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_enable,
  input logic [AW-1:0] ring_start,
  input logic [AW-1:0] ring_end,
  input logic          in_valid,
  input logic          in_eof,
  input logic          pend_dec,
  input logic          err_clr,
  input logic          glob_ie,
  input logic [AW-1:0] hw_wr_ptr,
  input logic [CW-1:0] pend_count,
  input logic          pkt_flag,
  input logic          err_flag,
  input logic          irq
);
  // R6: pointer holds while no byte arrives
  a_r6_wp_still_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && !in_valid) |=> (!rx_enable || $stable(hw_wr_ptr)));

  // R6 / R7: count moves only on a last byte or a host decrement
  a_r6_count_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_eof) && !pend_dec) |=> $stable(pend_count));

  // R6 / R9: count moves by at most one
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_count == $past(pend_count) ||
              pend_count == $past(pend_count) + 1'b1 ||
              pend_count + 1'b1 == $past(pend_count)));

  // R5: frames start on even addresses
  a_r5_wp_even: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && $past(rx_enable) && !ring_start[0]) |-> !hw_wr_ptr[0]);

  // R4: pointer stays inside the ring
  a_r4_wp_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && $past(rx_enable)) |-> (hw_wr_ptr >= ring_start && hw_wr_ptr <= ring_end));

  // R9: error flag is sticky until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R10: interrupt needs global enable and a flag
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (glob_ie && (pkt_flag || err_flag)));
endmodule

bind ring_rx_writer ring_rx_writer_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/test_ring_rx_writer.sv
module test_ring_rx_writer;
  localparam logic [7:0] RS = 8'h10;
  localparam logic [7:0] RE = 8'h4F;
  localparam int NF = 8;
  // {length, status, pass}
  localparam logic [24:0] FR [NF] = '{
    {8'd10, 16'hA001, 1'b1}, {8'd7,  16'hB002, 1'b1}, {8'd1,  16'hC003, 1'b1},
    {8'd14, 16'hD004, 1'b0}, {8'd20, 16'hE005, 1'b1}, {8'd3,  16'hF006, 1'b1},
    {8'd2,  16'h1007, 1'b1}, {8'd9,  16'h2008, 1'b1}
  };

  logic clk, rst_n, rx_enable, in_valid, in_sof, in_eof, in_pass;
  logic pend_dec, err_clr, pkt_ie, err_ie, glob_ie;
  logic [7:0] ring_start, ring_end, host_tail, in_data, peek_addr, peek_data, hw_wr_ptr;
  logic [15:0] in_stat;
  logic [3:0] pend_count;
  logic pkt_flag, err_flag, irq;

  int checks = 0, errors = 0;
  logic [7:0] exp_wp;
  int exp_cnt;

  ring_rx_writer i_ring_rx_writer (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] adv(input logic [7:0] a);
    return (a == RE) ? RS : a + 8'd1;
  endfunction

  function automatic int free_of(input logic [7:0] wp, input logic [7:0] tl);
    if (tl > wp) return int'(tl) - int'(wp) - 1;
    return (int'(RE) - int'(RS) + 1) - (int'(wp) - int'(tl)) - 1;
  endfunction

  function automatic logic [7:0] dbyte(input int tag, input int i);
    return 8'((tag * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic send(input int len, input int tag, input logic [15:0] st, input logic pass);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = dbyte(tag, i); in_pass = pass; in_stat = st;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    peek_addr = a; #1; d = peek_data;
  endtask

  // sends one frame, models acceptance, checks pointer, count and stored bytes
  task automatic frame(input int n, input int tag, input logic [15:0] st, input logic pass,
                       output bit dropped);
    logic [7:0] old, a, nx, b;
    bit pd, acc;
    int need, fr;
    old = exp_wp; a = old;
    for (int k = 0; k < 6; k++) a = adv(a);
    for (int k = 0; k < n - 1; k++) a = adv(a);
    nx = adv(a); pd = nx[0];
    if (pd) nx = adv(nx);
    need = 6 + n + int'(pd);
    fr = free_of(old, host_tail);
    send(n, tag, st, pass);
    acc = pass && (need <= fr);
    dropped = pass && !acc;
    if (acc) begin
      exp_wp = nx;
      exp_cnt = (exp_cnt < 15) ? exp_cnt + 1 : 15;
    end
    chk(hw_wr_ptr == exp_wp, acc ? "R6 pointer to link" : "R7/R8 pointer kept", hw_wr_ptr, exp_wp);
    chk(int'(pend_count) == exp_cnt, "R6 count", pend_count, exp_cnt);
    if (acc) begin
      chk(pkt_flag == 1'b1, "R6 flag", pkt_flag, 1);
      a = old;
      peek(a, b); chk(b == nx, "R2 link low", b, nx); a = adv(a);
      peek(a, b); chk(b == 8'h00, "R2 link high", b, 0); a = adv(a);
      peek(a, b); chk(b == 8'(n), "R2 count low", b, n); a = adv(a);
      peek(a, b); chk(b == 8'(n >> 8), "R2 count high", b, n >> 8); a = adv(a);
      peek(a, b); chk(b == st[7:0], "R2 stat low", b, st[7:0]); a = adv(a);
      peek(a, b); chk(b == st[15:8], "R2 stat high", b, st[15:8]); a = adv(a);
      for (int i = 0; i < n; i++) begin
        peek(a, b);
        chk(b == dbyte(tag, i), "R3/R4 data byte", b, dbyte(tag, i));
        a = adv(a);
      end
      chk(exp_wp[0] == 1'b0, "R5 even start", exp_wp, 0);
    end
  endtask

  initial begin
    bit dr;
    rst_n = 1'b0; rx_enable = 1'b0; ring_start = RS; ring_end = RE; host_tail = RS;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00; in_pass = 1'b0;
    in_stat = 16'h0; pend_dec = 1'b0; err_clr = 1'b0; pkt_ie = 1'b0; err_ie = 1'b0;
    glob_ie = 1'b0; peek_addr = 8'h00;
    #5;
    // R1 reset state
    chk(hw_wr_ptr == 8'h00, "R1 reset pointer", hw_wr_ptr, 0);
    chk(pend_count == 4'd0 && !pkt_flag && !err_flag && !irq, "R1 reset flags",
        {pend_count, pkt_flag, err_flag, irq}, 0);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(hw_wr_ptr == RS, "R1 pointer follows start", hw_wr_ptr, RS);
    exp_wp = RS; exp_cnt = 0;
    send(4, 99, 16'h5555, 1'b1);
    chk(hw_wr_ptr == RS && pend_count == 0 && !pkt_flag, "R1 disabled frame ignored",
        {hw_wr_ptr, pend_count}, {RS, 4'd0});

    rx_enable = 1'b1;
    @(negedge clk);
    // table of frames, tail follows the pointer so the ring wraps
    for (int f = 0; f < NF; f++) begin
      host_tail = exp_wp;
      frame(int'(FR[f][24:17]), f, FR[f][16:1], FR[f][0], dr);
      chk(err_flag == 1'b0, "R7 no error", err_flag, 0);
    end

    // R10 interrupt combine
    pkt_ie = 1'b1; glob_ie = 1'b1; #1;
    chk(irq == 1'b1, "R10 irq from received", irq, 1);
    glob_ie = 1'b0; #1;
    chk(irq == 1'b0, "R10 irq global off", irq, 0);

    // R9 decrement to zero
    while (exp_cnt > 0) begin
      @(negedge clk); pend_dec = 1'b1;
      @(negedge clk); pend_dec = 1'b0; exp_cnt--;
      chk(int'(pend_count) == exp_cnt, "R9 decrement", pend_count, exp_cnt);
    end
    chk(pkt_flag == 1'b0, "R9 flag clears at zero", pkt_flag, 0);
    pend_dec = 1'b1; @(negedge clk); pend_dec = 1'b0;
    chk(pend_count == 4'd0, "R9 no underflow", pend_count, 0);

    // R8 boundary: free 15, odd frame of 9 needs 16 with padding
    host_tail = exp_wp;
    for (int k = 0; k < 16; k++) host_tail = adv(host_tail);
    frame(9, 40, 16'h3333, 1'b1, dr);
    chk(dr == 1'b1 && err_flag == 1'b1, "R8 drop sets error", err_flag, 1);
    err_ie = 1'b1; glob_ie = 1'b1; #1;
    chk(irq == 1'b1, "R10 irq from error", irq, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(err_flag == 1'b0, "R9 error cleared", err_flag, 0);
    frame(30, 41, 16'h4444, 1'b0, dr);
    chk(err_flag == 1'b0, "R7 failed frame raises no error", err_flag, 0);
    host_tail = adv(host_tail);
    frame(9, 42, 16'h6666, 1'b1, dr);
    chk(dr == 1'b0 && err_flag == 1'b0, "R8 exact fit accepted", err_flag, 0);

    // R9 drop wins over clear in the same cycle
    host_tail = exp_wp;
    for (int k = 0; k < 4; k++) host_tail = adv(host_tail);
    fork
      frame(5, 43, 16'h7777, 1'b1, dr);
      begin
        repeat (5) @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
      end
    join
    chk(err_flag == 1'b1, "R9 drop wins over clear", err_flag, 1);

    // R11 saturation
    for (int f = 0; f < 17; f++) begin
      host_tail = exp_wp;
      frame(2, 60 + f, 16'h0F00, 1'b1, dr);
    end
    chk(pend_count == 4'd15, "R11 count saturates", pend_count, 15);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule